// File: doc/BRIEF.md
# E1 Transmit Timeslot Substitution Unit

This unit lives in the transmit path of an E1 framer. It sits between the serial backplane stream and the line. Every frame is 32 timeslots of 8 bits. The unit follows the frame position using a single frame-sync pulse. For each timeslot it decides whether the backplane byte goes to the line unchanged or is replaced. A replacement is one of three sources: an idle code shared by all slots, a code stored for that one slot, or the byte arriving from the line's receive side in the same slot (per-slot loopback).

A plain write-only register port holds the configuration. This covers two slot bitmaps, a bank of per-slot codes, the shared idle code and a mode bit. The mode bit decides whether the first bitmap means "insert idle code" or "loop receive data back". The second bitmap always means "insert this slot's own code" and overrides the first. Receive and transmit are assumed to share one bit clock and one frame sync. The serial line output is registered, so it lags the serial inputs by one clock.

Top module: `e1_tx_slot_subst`

## Requirements
- R1: While rst_n is low, line_data is 0 and all configuration clears: both bitmaps are 0, all codes are 0x00, the idle code is 0x00 and the mode is idle insertion.
- R2: A slot selected by neither bitmap carries the backplane bit unchanged.
- R3: The first bitmap sits at addresses 0x20..0x23, and the second at 0x24..0x27. In each group, bit b of the byte at offset k selects slot 8k+b+1. So bit 0 of the first byte is slot 1 and bit 7 of the last byte is slot 32.
- R4: With the mode register (address 0x29, bit 0) at 0, a slot selected by the first bitmap carries the idle code held at address 0x28.
- R5: With mode bit 0 at 1, a slot selected by the first bitmap carries rx_data in the same bit position of the same slot. Any set of slots may be looped.
- R6: A slot selected by the second bitmap carries its own code. The code for slot n is at address n-1 (0x00..0x1F).
- R7: When both bitmaps select a slot, the per-slot code wins over the idle code and over loopback data.
- R8: Every inserted byte leaves most significant bit first: bit 7 in the first bit time of the slot, bit 0 in the last.
- R9: Substitution choice and code byte are fixed at the first bit of each slot. A register write during the slot takes effect from the next slot boundary onward.
- R10: The bit presented with fsync high is bit 7 position of slot 1. Slot and bit counting restart on every fsync.
- R11: line_data shows the result for the input bit sampled at a rising clock edge, starting just after that edge. This is a latency of one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared bit clock for transmit and receive streams |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | One-clock pulse marking the first bit of slot 1 |
| bp_data | input | 1 | Serial data from the backplane |
| rx_data | input | 1 | Serial data received from the line, aligned to bp_data |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Register write address |
| wr_data | input | 8 | Register write data |
| line_data | output | 1 | Serial data towards the line |

## Verification
The assertions take for granted that rx_data and bp_data are bit-aligned in the same slot under one clock and one frame sync. They also assume a register write lands in the registers at the edge on which it is strobed. The bench drives both serial streams from the same per-bit loop and raises fsync only on the first bit of each 256-bit frame. The one exception is a few bare write cycles between frames, after which a fresh fsync realigns the counters. Mid-slot writes are placed at chosen bit positions inside running frames, so that the slot-boundary latching is exercised without breaking alignment.

// File: rtl/e1ts_pkg.sv
package e1ts_pkg;

   // Source feeding the line for the current slot
   typedef enum logic [1:0] {
      SRC_PASS = 2'd0,
      SRC_IDLE = 2'd1,
      SRC_LOOP = 2'd2,
      SRC_CODE = 2'd3
   } src_e;

   localparam int unsigned DEF_NUM_SLOTS = 32;
   localparam int unsigned DEF_SLOT_BITS = 8;
   localparam int unsigned DEF_ADDR_W    = 7;

   // Number of byte-wide registers needed to hold one slot bitmap
   function automatic int unsigned map_regs(input int unsigned slots, input int unsigned width);
      return (slots + width - 1) / width;
   endfunction

endpackage

// File: rtl/e1ts_slot_timer.sv
module e1ts_slot_timer #(
   parameter int unsigned NUM_SLOTS = 32,
   parameter int unsigned SLOT_BITS = 8,
   localparam int unsigned SLOT_W = $clog2(NUM_SLOTS),
   localparam int unsigned BIT_W  = $clog2(SLOT_BITS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fsync,
   output logic [SLOT_W-1:0] cur_slot,
   output logic [BIT_W-1:0]  cur_bit,
   output logic              slot_start
);

   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);
   localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(SLOT_BITS - 1);

   generate
      if (NUM_SLOTS < 2) begin : g_bad_slots
         $error("e1ts_slot_timer: NUM_SLOTS must be at least 2");
      end
      if ((1 << BIT_W) != SLOT_BITS) begin : g_bad_bits
         $error("e1ts_slot_timer: SLOT_BITS must be a power of two");
      end
   endgenerate

   logic [SLOT_W-1:0] slot_q;
   logic [BIT_W-1:0]  bit_q;
   logic [SLOT_W-1:0] slot_nx;
   logic [BIT_W-1:0]  bit_nx;

   // Frame sync forces position zero in the very cycle it is seen
   assign cur_slot   = fsync ? '0 : slot_q;
   assign cur_bit    = fsync ? '0 : bit_q;
   assign slot_start = (cur_bit == '0);

   always_comb begin
      slot_nx = cur_slot;
      bit_nx  = cur_bit + 1'b1;
      if (cur_bit == LAST_BIT) begin
         bit_nx  = '0;
         slot_nx = (cur_slot == LAST_SLOT) ? '0 : cur_slot + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= '0;
         bit_q  <= '0;
      end else begin
         slot_q <= slot_nx;
         bit_q  <= bit_nx;
      end
   end

   AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      fsync |=> (slot_q == '0) && (bit_q == BIT_W'(1))); // R10

   AST_SLOT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (!fsync && bit_q == LAST_BIT && slot_q != LAST_SLOT)
      |=> (bit_q == '0) && (slot_q == SLOT_W'($past(slot_q) + 1'b1))); // R10

   AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!fsync && bit_q == LAST_BIT && slot_q == LAST_SLOT)
      |=> (bit_q == '0) && (slot_q == '0)); // R10

endmodule

// File: rtl/e1ts_regs.sv
module e1ts_regs
   import e1ts_pkg::*;
#(
   parameter int unsigned NUM_SLOTS = 32,
   parameter int unsigned SLOT_BITS = 8,
   parameter int unsigned ADDR_W    = 7
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 wr_en,
   input  logic [ADDR_W-1:0]                    wr_addr,
   input  logic [SLOT_BITS-1:0]                 wr_data,
   output logic [NUM_SLOTS-1:0][SLOT_BITS-1:0]  code_bank,
   output logic [NUM_SLOTS-1:0]                 map_shared,
   output logic [NUM_SLOTS-1:0]                 map_code,
   output logic [SLOT_BITS-1:0]                 idle_code,
   output logic                                 loop_mode
);

   localparam int unsigned MAP_REGS  = map_regs(NUM_SLOTS, SLOT_BITS);
   localparam int unsigned CODE_BASE = 0;
   localparam int unsigned SHR_BASE  = CODE_BASE + NUM_SLOTS;
   localparam int unsigned CMAP_BASE = SHR_BASE + MAP_REGS;
   localparam int unsigned IDLE_ADDR = CMAP_BASE + MAP_REGS;
   localparam int unsigned MODE_ADDR = IDLE_ADDR + 1;

   generate
      if (MODE_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("e1ts_regs: ADDR_W too narrow for the register map");
      end
      if ((NUM_SLOTS % SLOT_BITS) != 0) begin : g_bad_lanes
         $error("e1ts_regs: NUM_SLOTS must be a multiple of SLOT_BITS");
      end
   endgenerate

   // Per-slot code registers
   generate
      for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_code
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               code_bank[s] <= '0;
            end else if (wr_en && wr_addr == ADDR_W'(CODE_BASE + s)) begin
               code_bank[s] <= wr_data;
            end
         end
      end
   endgenerate

   // Bitmap lanes: lane k bit b selects slot k*SLOT_BITS + b
   generate
      for (genvar k = 0; k < MAP_REGS; k++) begin : g_lane
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               map_shared[k*SLOT_BITS +: SLOT_BITS] <= '0;
            end else if (wr_en && wr_addr == ADDR_W'(SHR_BASE + k)) begin
               map_shared[k*SLOT_BITS +: SLOT_BITS] <= wr_data;
            end
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               map_code[k*SLOT_BITS +: SLOT_BITS] <= '0;
            end else if (wr_en && wr_addr == ADDR_W'(CMAP_BASE + k)) begin
               map_code[k*SLOT_BITS +: SLOT_BITS] <= wr_data;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_code <= '0;
         loop_mode <= 1'b0;
      end else if (wr_en) begin
         if (wr_addr == ADDR_W'(IDLE_ADDR)) idle_code <= wr_data;
         if (wr_addr == ADDR_W'(MODE_ADDR)) loop_mode <= wr_data[0];
      end
   end

   AST_IDLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(IDLE_ADDR)) |=> idle_code == $past(wr_data)); // R4

   AST_MODE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(MODE_ADDR)) |=> loop_mode == $past(wr_data[0])); // R5

endmodule

// File: rtl/e1ts_sel.sv
module e1ts_sel
   import e1ts_pkg::*;
#(
   parameter int unsigned NUM_SLOTS = 32,
   parameter int unsigned SLOT_BITS = 8,
   parameter bit          REG_OUT   = 1'b1,
   localparam int unsigned SLOT_W = $clog2(NUM_SLOTS),
   localparam int unsigned BIT_W  = $clog2(SLOT_BITS)
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [SLOT_W-1:0]                    cur_slot,
   input  logic [BIT_W-1:0]                     cur_bit,
   input  logic                                 slot_start,
   input  logic [NUM_SLOTS-1:0][SLOT_BITS-1:0]  code_bank,
   input  logic [NUM_SLOTS-1:0]                 map_shared,
   input  logic [NUM_SLOTS-1:0]                 map_code,
   input  logic [SLOT_BITS-1:0]                 idle_code,
   input  logic                                 loop_mode,
   input  logic                                 bp_data,
   input  logic                                 rx_data,
   output logic                                 line_data
);

   src_e                 fresh_src;
   logic [SLOT_BITS-1:0] fresh_byte;
   src_e                 src_q;
   logic [SLOT_BITS-1:0] byte_q;
   src_e                 eff_src;
   logic [SLOT_BITS-1:0] eff_byte;
   logic [BIT_W-1:0]     msb_idx;
   logic                 next_bit;

   // Decision for the slot that begins now; per-slot code has priority
   always_comb begin
      fresh_src = SRC_PASS;
      if (map_code[cur_slot]) begin
         fresh_src = SRC_CODE;
      end else if (map_shared[cur_slot]) begin
         fresh_src = loop_mode ? SRC_LOOP : SRC_IDLE;
      end
      fresh_byte = map_code[cur_slot] ? code_bank[cur_slot] : idle_code;
   end

   // Hold the decision for the remaining bits of the slot
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q  <= SRC_PASS;
         byte_q <= '0;
      end else if (slot_start) begin
         src_q  <= fresh_src;
         byte_q <= fresh_byte;
      end
   end

   assign eff_src  = slot_start ? fresh_src  : src_q;
   assign eff_byte = slot_start ? fresh_byte : byte_q;
   // Bit 0 of the slot carries the most significant code bit
   assign msb_idx  = BIT_W'(SLOT_BITS - 1) - cur_bit;

   always_comb begin
      unique case (eff_src)
         SRC_IDLE,
         SRC_CODE: next_bit = eff_byte[msb_idx];
         SRC_LOOP: next_bit = rx_data;
         default:  next_bit = bp_data;
      endcase
   end

   generate
      if (REG_OUT) begin : g_reg_out
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) line_data <= 1'b0;
            else        line_data <= next_bit;
         end

         AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
            (!map_code[cur_slot] && !map_shared[cur_slot] && slot_start)
            |=> line_data == $past(bp_data)); // R2

         AST_LOOP_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_start && !map_code[cur_slot] && map_shared[cur_slot] && loop_mode)
            |=> line_data == $past(rx_data)); // R5

         AST_CODE_MSB: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_start && map_code[cur_slot])
            |=> line_data == $past(code_bank[cur_slot][SLOT_BITS-1])); // R8
      end else begin : g_comb_out
         assign line_data = next_bit;
      end
   endgenerate

endmodule

// File: rtl/e1_tx_slot_subst.sv
module e1_tx_slot_subst
   import e1ts_pkg::*;
#(
   parameter int unsigned NUM_SLOTS = DEF_NUM_SLOTS,
   parameter int unsigned SLOT_BITS = DEF_SLOT_BITS,
   parameter int unsigned ADDR_W    = DEF_ADDR_W,
   parameter bit          REG_OUT   = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 fsync,
   input  logic                 bp_data,
   input  logic                 rx_data,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [SLOT_BITS-1:0] wr_data,
   output logic                 line_data
);

   localparam int unsigned SLOT_W = $clog2(NUM_SLOTS);
   localparam int unsigned BIT_W  = $clog2(SLOT_BITS);

   logic [SLOT_W-1:0]                   cur_slot;
   logic [BIT_W-1:0]                    cur_bit;
   logic                                slot_start;
   logic [NUM_SLOTS-1:0][SLOT_BITS-1:0] code_bank;
   logic [NUM_SLOTS-1:0]                map_shared;
   logic [NUM_SLOTS-1:0]                map_code;
   logic [SLOT_BITS-1:0]                idle_code;
   logic                                loop_mode;

   e1ts_slot_timer #(
      .NUM_SLOTS (NUM_SLOTS),
      .SLOT_BITS (SLOT_BITS)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .fsync      (fsync),
      .cur_slot   (cur_slot),
      .cur_bit    (cur_bit),
      .slot_start (slot_start)
   );

   e1ts_regs #(
      .NUM_SLOTS (NUM_SLOTS),
      .SLOT_BITS (SLOT_BITS),
      .ADDR_W    (ADDR_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .code_bank  (code_bank),
      .map_shared (map_shared),
      .map_code   (map_code),
      .idle_code  (idle_code),
      .loop_mode  (loop_mode)
   );

   e1ts_sel #(
      .NUM_SLOTS (NUM_SLOTS),
      .SLOT_BITS (SLOT_BITS),
      .REG_OUT   (REG_OUT)
   ) u_sel (
      .clk        (clk),
      .rst_n      (rst_n),
      .cur_slot   (cur_slot),
      .cur_bit    (cur_bit),
      .slot_start (slot_start),
      .code_bank  (code_bank),
      .map_shared (map_shared),
      .map_code   (map_code),
      .idle_code  (idle_code),
      .loop_mode  (loop_mode),
      .bp_data    (bp_data),
      .rx_data    (rx_data),
      .line_data  (line_data)
   );

   AST_RESET_LOW: assert property (@(posedge clk)
      !rst_n |=> (!$past(rst_n) && !rst_n) -> (line_data == 1'b0)); // R1

endmodule

// File: tb/tb_e1_tx_slot_subst.sv
module tb_e1_tx_slot_subst;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       fsync;
   logic       bp_data;
   logic       rx_data;
   logic       wr_en;
   logic [6:0] wr_addr;
   logic [7:0] wr_data;
   logic       line_data;

   int checks = 0;
   int errors = 0;
   string cur_req = "R1";
   bit done = 1'b0;

   always #10ns clk = ~clk;

   e1_tx_slot_subst dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .fsync     (fsync),
      .bp_data   (bp_data),
      .rx_data   (rx_data),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .line_data (line_data)
   );

   // ---------------- behavioural reference ----------------
   logic [7:0]  m_code [32];
   logic [31:0] m_shr;
   logic [31:0] m_cmap;
   logic [7:0]  m_idle;
   bit          m_loop;
   int          m_pos;      // bit position within frame, 0..255
   int          m_kind;     // 0 pass, 1 idle, 2 loop, 3 code
   logic [7:0]  m_byte;
   logic        exp_line = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 32; i++) m_code[i] = 8'h00;
         m_shr = '0; m_cmap = '0; m_idle = '0; m_loop = 0;
         m_pos = 0; m_kind = 0; m_byte = '0; exp_line = 1'b0;
      end else begin
         int pos;
         int slot;
         int bitn;
         pos  = fsync ? 0 : m_pos;
         slot = pos / 8;
         bitn = pos % 8;
         if (bitn == 0) begin
            if (m_cmap[slot])      begin m_kind = 3; m_byte = m_code[slot]; end
            else if (m_shr[slot])  begin m_kind = m_loop ? 2 : 1; m_byte = m_idle; end
            else                   begin m_kind = 0; m_byte = m_idle; end
         end
         case (m_kind)
            1, 3:    exp_line = m_byte[7-bitn];
            2:       exp_line = rx_data;
            default: exp_line = bp_data;
         endcase
         m_pos = (pos + 1) % 256;
         if (wr_en) begin
            if (wr_addr < 7'h20)                          m_code[wr_addr] = wr_data;
            else if (wr_addr >= 7'h20 && wr_addr < 7'h24) m_shr[(wr_addr-7'h20)*8 +: 8] = wr_data;
            else if (wr_addr >= 7'h24 && wr_addr < 7'h28) m_cmap[(wr_addr-7'h24)*8 +: 8] = wr_data;
            else if (wr_addr == 7'h28)                    m_idle = wr_data;
            else if (wr_addr == 7'h29)                    m_loop = wr_data[0];
         end
      end
   end

   // Compare against the reference on every clock, away from the edge
   bit cmp_on = 1'b0;
   always @(negedge clk) begin
      if (cmp_on && !done) begin
         checks++;
         if (line_data !== exp_line) begin
            errors++;
            $display("FAIL %s per-clock: line_data=%0b expected=%0b at %0t", cur_req, line_data, exp_line, $time);
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   function automatic logic [7:0] bp_byte(int f, int s);
      return 8'((s * 37) + (f * 11) + 5);
   endfunction

   function automatic logic [7:0] rx_byte(int f, int s);
      return 8'((s * 91) ^ (f * 3) ^ 8'hC6);
   endfunction

   logic [7:0] out_b [32];

   task automatic check_val(string req, string what, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
      end
   endtask

   task automatic reg_write(logic [6:0] a, logic [7:0] d);
      @(negedge clk);
      fsync = 0; bp_data = 0; rx_data = 0;
      wr_en = 1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 0;
   endtask

   // One frame; optional write at (mw_slot, mw_bit); collects output bytes
   task automatic run_frame(int f, bit mw, int mw_slot, int mw_bit, logic [6:0] mw_a, logic [7:0] mw_d);
      int ps = -1;
      int pb = 0;
      for (int s = 0; s < 32; s++) begin
         for (int b = 0; b < 8; b++) begin
            @(negedge clk);
            if (ps >= 0) out_b[ps][7-pb] = line_data;
            fsync   = (s == 0 && b == 0);
            bp_data = bp_byte(f, s)[7-b];
            rx_data = rx_byte(f, s)[7-b];
            wr_en   = mw && (s == mw_slot) && (b == mw_bit);
            wr_addr = mw_a;
            wr_data = mw_d;
            ps = s; pb = b;
         end
      end
      @(negedge clk);
      out_b[ps][7-pb] = line_data;
      fsync = 0; wr_en = 0; bp_data = 0; rx_data = 0;
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(20ns * 200000);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   // ---------------- main sequence ----------------
   initial begin
      rst_n = 0; fsync = 0; bp_data = 0; rx_data = 0;
      wr_en = 0; wr_addr = '0; wr_data = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      cmp_on = 1'b1;
      // R1: reset holds output low
      check_val("R1", "line_data in reset", {7'b0, line_data}, 8'h00);
      rst_n = 1;

      // R1 R2 R10 R11: defaults give pure pass-through with one-clock lag
      cur_req = "R2";
      run_frame(0, 0, 0, 0, '0, '0);
      for (int s = 0; s < 32; s++) check_val("R2", $sformatf("pass slot%0d", s+1), out_b[s], bp_byte(0, s));
      check_val("R10", "slot1 follows fsync", out_b[0], bp_byte(0, 0));

      // R3 R4: shared idle code in slots 1, 13, 32
      cur_req = "R4";
      reg_write(7'h28, 8'hA5);
      reg_write(7'h20, 8'h01);
      reg_write(7'h21, 8'h10);
      reg_write(7'h23, 8'h80);
      run_frame(1, 0, 0, 0, '0, '0);
      check_val("R3", "slot1 idle", out_b[0], 8'hA5);
      check_val("R4", "slot13 idle", out_b[12], 8'hA5);
      check_val("R3", "slot32 idle", out_b[31], 8'hA5);
      check_val("R2", "slot2 unselected", out_b[1], bp_byte(1, 1));

      // R5: loopback from receive side
      cur_req = "R5";
      reg_write(7'h29, 8'h01);
      run_frame(2, 0, 0, 0, '0, '0);
      check_val("R5", "slot1 loop", out_b[0], rx_byte(2, 0));
      check_val("R5", "slot13 loop", out_b[12], rx_byte(2, 12));
      check_val("R5", "slot32 loop", out_b[31], rx_byte(2, 31));
      check_val("R2", "slot31 unselected", out_b[30], bp_byte(2, 30));

      // R6 R7 R8: per-slot codes, overriding loopback on slots 13 and 32
      cur_req = "R6";
      reg_write(7'h02, 8'h3C);
      reg_write(7'h0C, 8'h5E);
      reg_write(7'h1F, 8'h81);
      reg_write(7'h05, 8'h99);
      reg_write(7'h24, 8'h04);
      reg_write(7'h25, 8'h10);
      reg_write(7'h27, 8'h80);
      run_frame(3, 0, 0, 0, '0, '0);
      check_val("R6", "slot3 code", out_b[2], 8'h3C);
      check_val("R7", "slot13 code over loop", out_b[12], 8'h5E);
      check_val("R8", "slot32 code MSB first", out_b[31], 8'h81);
      check_val("R5", "slot1 still looped", out_b[0], rx_byte(3, 0));

      // R7: code also beats idle insertion
      cur_req = "R7";
      reg_write(7'h29, 8'h00);
      run_frame(4, 0, 0, 0, '0, '0);
      check_val("R7", "slot13 code over idle", out_b[12], 8'h5E);
      check_val("R4", "slot1 idle again", out_b[0], 8'hA5);

      // R9: bitmap write in the middle of slot 6
      cur_req = "R9";
      run_frame(5, 1, 5, 3, 7'h24, 8'h24);
      check_val("R9", "slot6 unchanged mid-slot", out_b[5], bp_byte(5, 5));
      run_frame(6, 0, 0, 0, '0, '0);
      check_val("R9", "slot6 code next frame", out_b[5], 8'h99);

      // R9: code write in the middle of slot 3
      run_frame(7, 1, 2, 4, 7'h02, 8'h00);
      check_val("R9", "slot3 old code kept", out_b[2], 8'h3C);
      run_frame(8, 0, 0, 0, '0, '0);
      check_val("R9", "slot3 new code", out_b[2], 8'h00);

      // R10: realign after an odd number of bare cycles
      cur_req = "R10";
      repeat (5) @(negedge clk);
      run_frame(9, 0, 0, 0, '0, '0);
      check_val("R10", "slot3 after realign", out_b[2], 8'h00);
      check_val("R11", "slot2 pass after realign", out_b[1], bp_byte(9, 1));

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule